// File: doc/BRIEF.md
# One-Shot Match Timer

A memory-mapped timer with a 32-bit count, a single match value, a status flag and an interrupt enable, reached over a simple 32-bit register bus. Software writes a match value to arm one event. The timer then counts down the ticks left until the count reaches that value, fires once and stops. When it fires, the count takes the match value. If the enable register is nonzero, the status flag also sets and drives a level interrupt.

Ticks come from an internal divider of the bus clock, one tick every `TICK_DIV` clocks. With a 100 MHz bus clock, the default of 2 gives a 50 MHz tick. Software clears a pending event by writing zero to the status register.

The block keeps the stored count (the value taken at the last hit), the match value and the ticks still remaining. The count seen by software is the match value minus the remaining ticks, so it advances by one per tick while the timer is armed.

Top module: `omt_timer`

## Requirements
- R1: After reset, reads at offsets 0x10, 0x14 and 0x1C return 0. The interrupt is low, and no event occurs until the match register is written.
- R2: A read (bus_valid=1, bus_write=0) returns its data on bus_rdata after the next rising clock edge, and bus_rdata holds between reads. Offset 0x10 gives the elapsed count, 0x14 gives the status (bit 0) and 0x1C gives the enable word. Every other offset, including the write-only match offset 0x00, reads 0.
- R3: A write to offset 0x00 stores the match value M and arms the timer. The distance D is computed from the stored count C, which is 0 after reset and the match value after each hit. If M > C, then D = M - C. Otherwise D = M + (0xFFFFFFFF - C), modulo 2^32. The elapsed count read at 0x10 is M minus the remaining ticks, so it reads C (or C+1 when the count wraps) right after arming.
- R4: One tick occurs every TICK_DIV bus clocks. The event fires on the D-th tick after arming. With the default TICK_DIV=2, this is between 2D-1 and 2D clocks after the write edge.
- R5: On the event, the stored count becomes M and the timer stops. No further event occurs until offset 0x00 is written again.
- R6: On the event, if the enable word at 0x1C is nonzero, status becomes 1. If the enable word is zero, status is unchanged and only the count snaps.
- R7: Writing 0 to offset 0x14 clears status. Writing a nonzero value there is ignored. If an event fires in the same cycle as the clear, the event sets status.
- R8: The irq output is high exactly while status is 1.
- R9: If a match write and an event fall in the same cycle, the write wins: the event is discarded and the timer is re-armed from the new match value.
- R10: Writes to any offset other than 0x00, 0x14 and 0x1C are ignored, including 0x10. They neither change the count nor arm the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt, high while status is set |

## Verification
Read data is due one clock after the read request, and a status clear removes irq one clock after the write. The bench therefore drives each access at a falling edge and samples at the next falling edge. An event is due on the D-th tick after the arming edge, and the divider phase is not known to the bench. For that reason the bench checks that irq is still low 2D-2 clocks after the write and high by 2D clocks. Elapsed-count reads taken just after arming accept either of the two values that one possible tick allows. The same-cycle collision of a write and an event is forced by writing the match register on three consecutive edges, so that whichever edge carries the tick meets a write.

// File: rtl/omt_pkg.sv
package omt_pkg;

    parameter int unsigned OMT_W = 32;

    typedef logic [OMT_W-1:0] omt_word_t;

    localparam logic [7:0] OFF_MATCH  = 8'h00;
    localparam logic [7:0] OFF_COUNT  = 8'h10;
    localparam logic [7:0] OFF_STATUS = 8'h14;
    localparam logic [7:0] OFF_ENABLE = 8'h1C;

    typedef struct packed {
        omt_word_t match;
        omt_word_t base;
        omt_word_t remain;
        logic      running;
    } core_state_t;

    typedef struct packed {
        logic      status;
        omt_word_t ien;
        omt_word_t rdata;
    } regs_state_t;

endpackage

// File: rtl/omt_tick_div.sv
module omt_tick_div #(
    parameter int unsigned TICK_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);

    generate
        if (TICK_DIV <= 1) begin : g_every
            assign tick_o = 1'b1;
        end else begin : g_div
            localparam int unsigned CW = $clog2(TICK_DIV);
            localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign tick_o = (cnt_q == LAST);

            AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o); // R4
        end
    endgenerate

endmodule

// File: rtl/omt_core.sv
module omt_core
    import omt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick_i,
    input  logic      arm_i,
    input  omt_word_t arm_val_i,
    output logic      hit_o,
    output omt_word_t elapsed_o
);

    localparam omt_word_t ALL_ONES = '1;
    localparam omt_word_t ONE      = omt_word_t'(1);

    core_state_t q, d;
    logic        due;

    always_comb begin
        d   = q;
        due = tick_i && q.running && (q.remain <= ONE);
        if (arm_i) begin
            d.match   = arm_val_i;
            d.running = 1'b1;
            if (arm_val_i > q.base) d.remain = arm_val_i - q.base;
            else                    d.remain = arm_val_i + (ALL_ONES - q.base);
        end else if (due) begin
            d.remain  = '0;
            d.running = 1'b0;
            d.base    = q.match;
        end else if (tick_i && q.running) begin
            d.remain  = q.remain - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign hit_o     = due && !arm_i;
    assign elapsed_o = q.match - q.remain;

    AST_ARM_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> q.running); // R3

    AST_HIT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |=> (!q.running && q.base == q.match)); // R5

    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.running && !arm_i) |=> (!q.running && $stable(q.remain))); // R5

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_i && tick_i && q.running) |=> (q.running && q.match == $past(arm_val_i))); // R9

endmodule

// File: rtl/omt_regs.sv
module omt_regs
    import omt_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  omt_word_t         bus_wdata,
    input  logic              hit_i,
    input  omt_word_t         elapsed_i,
    output logic              arm_o,
    output omt_word_t         rdata_o,
    output logic              irq_o
);

    regs_state_t q, d;
    logic wr, rd, sel_match, sel_count, sel_status, sel_enable;

    always_comb begin
        wr         = bus_valid && bus_write;
        rd         = bus_valid && !bus_write;
        sel_match  = (bus_addr == ADDR_W'(OFF_MATCH));
        sel_count  = (bus_addr == ADDR_W'(OFF_COUNT));
        sel_status = (bus_addr == ADDR_W'(OFF_STATUS));
        sel_enable = (bus_addr == ADDR_W'(OFF_ENABLE));

        d = q;
        if (hit_i && q.ien != '0)
            d.status = 1'b1;
        else if (wr && sel_status && bus_wdata == '0)
            d.status = 1'b0;

        if (wr && sel_enable)
            d.ien = bus_wdata;

        if (rd) begin
            if (sel_count)       d.rdata = elapsed_i;
            else if (sel_status) d.rdata = omt_word_t'(q.status);
            else if (sel_enable) d.rdata = q.ien;
            else                 d.rdata = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign arm_o   = wr && sel_match;
    assign rdata_o = q.rdata;
    assign irq_o   = q.status;

    AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.status) |-> $past(hit_i && q.ien != '0)); // R6

    AST_SET_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && q.ien != '0) |=> q.status); // R6

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel_status && bus_wdata == '0 && !hit_i) |=> !q.status); // R7

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !sel_count && !sel_status && !sel_enable) |=> (q.rdata == '0)); // R2

endmodule

// File: rtl/omt_timer.sv
module omt_timer
    import omt_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned TICK_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [OMT_W-1:0]  bus_wdata,
    output logic [OMT_W-1:0]  bus_rdata,
    output logic              irq
);

    logic      tick, arm, hit;
    omt_word_t elapsed;

    omt_tick_div #(.TICK_DIV(TICK_DIV)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    omt_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .arm_i     (arm),
        .arm_val_i (bus_wdata),
        .hit_o     (hit),
        .elapsed_o (elapsed)
    );

    omt_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .hit_i     (hit),
        .elapsed_i (elapsed),
        .arm_o     (arm),
        .rdata_o   (bus_rdata),
        .irq_o     (irq)
    );

    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(bus_valid && bus_write && bus_addr == ADDR_W'(OFF_STATUS))) |=> irq); // R8

endmodule

// File: tb/sim_omt_timer.sv
`timescale 1ns/1ps
module sim_omt_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    omt_timer u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'h10, 32'h0,         4'd1},  // R1 count
        '{1'b0, 8'h14, 32'h0,         4'd1},  // R1 status
        '{1'b0, 8'h1C, 32'h0,         4'd1},  // R1 enable
        '{1'b0, 8'h00, 32'h0,         4'd2},  // R2 match is write-only
        '{1'b1, 8'h1C, 32'hA5A5_0001, 4'd2},
        '{1'b0, 8'h1C, 32'hA5A5_0001, 4'd2},  // R2 enable readback
        '{1'b0, 8'h04, 32'h0,         4'd2},  // R2 unmapped
        '{1'b0, 8'h18, 32'h0,         4'd2},  // R2 unmapped
        '{1'b1, 8'h1C, 32'h0,         4'd2},
        '{1'b0, 8'h1C, 32'h0,         4'd2},
        '{1'b1, 8'h10, 32'h0000_1234, 4'd10}, // R10 count not writable
        '{1'b0, 8'h10, 32'h0,         4'd10},
        '{1'b0, 8'h14, 32'h0,         4'd10}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] v);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] v);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        v = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] r;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        check(irq == 1'b0, "R1", {31'b0, irq}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) bus_wr(VEC[i].addr, VEC[i].data);
            else begin
                bus_rd(VEC[i].addr, r);
                check(r == VEC[i].data, $sformatf("R%0d", VEC[i].req), r, VEC[i].data);
            end
        end

        // R10 / R1: nothing armed, no event
        wait_cyc(20);
        check(irq == 1'b0, "R10", {31'b0, irq}, 32'h0);

        // R4 R6: enable, arm match 5 from count 0, D=5
        bus_wr(8'h1C, 32'h1);
        bus_wr(8'h00, 32'd5);
        wait_cyc(8);
        check(irq == 1'b0, "R4 early", {31'b0, irq}, 32'h0);
        wait_cyc(2);
        check(irq == 1'b1, "R4 due", {31'b0, irq}, 32'h1);
        bus_rd(8'h14, r);
        check(r == 32'h1, "R6 status", r, 32'h1);
        bus_rd(8'h10, r);
        check(r == 32'd5, "R5 snap", r, 32'd5);
        wait_cyc(30);
        bus_rd(8'h10, r);
        check(r == 32'd5, "R5 stopped", r, 32'd5);

        // R7 R8: nonzero ignored, zero clears
        bus_wr(8'h14, 32'h7);
        check(irq == 1'b1, "R7 nonzero ignored", {31'b0, irq}, 32'h1);
        bus_wr(8'h14, 32'h0);
        check(irq == 1'b0, "R8 irq clear", {31'b0, irq}, 32'h0);
        bus_rd(8'h14, r);
        check(r == 32'h0, "R7 status clear", r, 32'h0);
        bus_wr(8'h14, 32'h0);
        bus_rd(8'h14, r);
        check(r == 32'h0, "R7 clear when clear", r, 32'h0);
        wait_cyc(40);
        check(irq == 1'b0, "R5 one-shot", {31'b0, irq}, 32'h0);

        // R3: arm 45 from 5, read elapsed at once
        bus_wr(8'h00, 32'd45);
        bus_rd(8'h10, r);
        check(r == 32'd5 || r == 32'd6, "R3 elapsed", r, 32'd5);
        // R9: re-arm mid-run with 11, D=6
        bus_wr(8'h00, 32'd11);
        wait_cyc(10);
        check(irq == 1'b0, "R9 rearm early", {31'b0, irq}, 32'h0);
        wait_cyc(2);
        check(irq == 1'b1, "R9 rearm due", {31'b0, irq}, 32'h1);
        bus_rd(8'h10, r);
        check(r == 32'd11, "R5 rearm snap", r, 32'd11);
        bus_wr(8'h14, 32'h0);

        // R6: disabled, arm 14 from 11
        bus_wr(8'h1C, 32'h0);
        bus_wr(8'h00, 32'd14);
        wait_cyc(10);
        check(irq == 1'b0, "R6 disabled irq", {31'b0, irq}, 32'h0);
        bus_rd(8'h14, r);
        check(r == 32'h0, "R6 disabled status", r, 32'h0);
        bus_rd(8'h10, r);
        check(r == 32'd14, "R5 disabled snap", r, 32'd14);

        // R9: writes on three consecutive edges, an event due on the 2nd or 3rd
        bus_wr(8'h1C, 32'h1);
        bus_wr(8'h00, 32'd15);
        bus_wr(8'h00, 32'd15);
        bus_wr(8'h00, 32'd20);
        check(irq == 1'b0, "R9 collision", {31'b0, irq}, 32'h0);
        wait_cyc(10);
        check(irq == 1'b0, "R9 new early", {31'b0, irq}, 32'h0);
        wait_cyc(2);
        check(irq == 1'b1, "R9 new due", {31'b0, irq}, 32'h1);
        bus_rd(8'h10, r);
        check(r == 32'd20, "R9 count", r, 32'd20);
        bus_wr(8'h14, 32'h0);

        // R3 wrap: match 7 below count 20 -> elapsed reads 21
        bus_wr(8'h00, 32'd7);
        bus_rd(8'h10, r);
        check(r == 32'd21 || r == 32'd22, "R3 wrap", r, 32'd21);
        wait_cyc(50);
        check(irq == 1'b0, "R3 wrap long", {31'b0, irq}, 32'h0);
        // R3 equal: match 20 equals count 20
        bus_wr(8'h00, 32'd20);
        bus_rd(8'h10, r);
        check(r == 32'd21 || r == 32'd22, "R3 equal", r, 32'd21);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'h0, 32'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule